// File: doc/BRIEF.md
# Burst Address Sequencer with Chip-Select Qualification

This block sits in front of a burstable synchronous memory array and produces the internal address the array uses on every clock. A burst begins when one of two active-low start strobes is seen together with a valid chip-enable combination. At that edge the external address is captured. Later edges with neither strobe active either step the low address bits to the next beat or hold them. The step is taken when the advance input is low; otherwise the address is held.

The low bits step in one of two orders, chosen by a mode input. The interleaved order XORs the beat number into the starting offset. The linear order adds the beat number modulo the beat count. The upper address bits never change inside a burst. Five chip enables of mixed polarity are examined only on strobe edges, and the resulting selection is held between those edges. The primary enable gates the first strobe: while it is high, that strobe is ignored.

Every output is registered, including a two-bit cycle-type code that tells downstream logic what happened on the last edge. The block has no streaming data path. All of its pins are plain control and status levels sampled on the rising clock edge, so no valid/ready handshake and no back-pressure apply.

Top module: `burst_seq`

## Requirements
- R1: While rst_n is low, and at the first sample after it is released, sel_q is 0, cyc_type is 2'b00 and mem_addr is all zeros.
- R2: On a strobe edge, the device is selected only when ce_main_n=0, ce_hi_a=1, ce_hi_b=1, ce_lo_a_n=0 and ce_lo_b_n=0. Any other combination gives sel_q=0 and cyc_type=2'b00 after that edge.
- R3: An edge is a strobe edge when stb_free_n is low, or when stb_gated_n is low with ce_main_n low. On every other edge the chip enables have no effect and sel_q keeps its value.
- R4: With ce_main_n high, a low on stb_gated_n is ignored. A low on stb_free_n with ce_main_n high deselects the device.
- R5: A strobe edge that selects the device loads ext_addr into mem_addr and reports cyc_type=2'b01 one clock later, whatever adv_n is. When both strobes are low, the result is the same single new burst.
- R6: With order_ilv=1, beat n of a burst drives low bits equal to the starting low bits XOR n.
- R7: With order_ilv=0, beat n drives low bits equal to the starting low bits plus n, modulo 2^LW.
- R8: During a burst the bits of mem_addr above the low LW bits stay equal to their loaded value. After 2^LW advances the low bits return to the start, with no carry into the upper bits.
- R9: While selected, an edge with no strobe and adv_n=0 advances one beat and reports 2'b10. With adv_n=1 mem_addr is held and 2'b11 is reported.
- R10: While deselected, an edge with no strobe reports 2'b00 and leaves mem_addr unchanged, whatever adv_n is.
- R11: sel_q, cyc_type and mem_addr all change on the same rising edge, one clock after the inputs that cause them. sel_q is 1 exactly when cyc_type is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | AW | External address captured at burst start |
| stb_gated_n | input | 1 | Start strobe, active low, gated by ce_main_n |
| stb_free_n | input | 1 | Start strobe, active low, not gated |
| adv_n | input | 1 | Advance to next beat, active low |
| order_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| ce_main_n | input | 1 | Primary chip enable, active low |
| ce_hi_a | input | 1 | Chip enable, active high |
| ce_hi_b | input | 1 | Chip enable, active high |
| ce_lo_a_n | input | 1 | Chip enable, active low |
| ce_lo_b_n | input | 1 | Chip enable, active low |
| mem_addr | output | AW | Registered internal array address |
| sel_q | output | 1 | Registered selection for the array |
| cyc_type | output | 2 | Last edge: 00 deselect, 01 new burst, 10 continue, 11 suspend |

## Verification
On every cycle the assertions check four things: that a load shows the captured external address, that the upper bits hold across steps, that the address is frozen when there is neither a load nor a step, and that the selection stays unchanged across edges where the gated strobe is masked. They also check that the selection and the cycle type agree at all times.

The exact beat orders cannot be shown by those per-cycle properties. That covers the XOR and modulo sequences from each of the four offsets in both modes, and the wrap back to the start. The interplay of a mid-burst suspension with a later advance is also left to the bench. So is the rejection of each single bad enable, which the bench scenarios compare against a reference model.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'b00,
    CYC_START = 2'b01,
    CYC_STEP  = 2'b10,
    CYC_WAIT  = 2'b11
  } cyc_e;
endpackage

// File: rtl/burst_seq_sel.sv
module burst_seq_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_gated_n,
  input  logic stb_free_n,
  input  logic ce_main_n,
  input  logic ce_hi_a,
  input  logic ce_hi_b,
  input  logic ce_lo_a_n,
  input  logic ce_lo_b_n,
  output logic strobe_edge,
  output logic enables_ok,
  output logic sel_q
);
  logic gated_take;

  // the gated strobe only counts while the primary enable is active
  assign gated_take  = !stb_gated_n && !ce_main_n;
  assign strobe_edge = gated_take || !stb_free_n;
  assign enables_ok  = !ce_main_n && ce_hi_a && ce_hi_b && !ce_lo_a_n && !ce_lo_b_n;

  always_ff @(posedge clk) begin
    if (!rst_n)           sel_q <= 1'b0;
    else if (strobe_edge) sel_q <= enables_ok;
  end

  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_free_n && ce_main_n) |=> $stable(sel_q)); // R4

  AST_BAD_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_free_n && (!ce_hi_a || ce_lo_b_n)) |=> !sel_q); // R2
endmodule

// File: rtl/burst_seq_ctl.sv
module burst_seq_ctl
  import burst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_edge,
  input  logic enables_ok,
  input  logic sel_q,
  input  logic adv_n,
  output logic load,
  output logic step,
  output cyc_e cyc_q
);
  cyc_e cyc_d;

  assign load = strobe_edge && enables_ok;
  assign step = !strobe_edge && sel_q && !adv_n;

  always_comb begin
    if (strobe_edge)  cyc_d = enables_ok ? CYC_START : CYC_IDLE;
    else if (!sel_q)  cyc_d = CYC_IDLE;
    else if (!adv_n)  cyc_d = CYC_STEP;
    else              cyc_d = CYC_WAIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_q <= CYC_IDLE;
    else        cyc_q <= cyc_d;
  end

  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != CYC_IDLE) == sel_q); // R11
endmodule

// File: rtl/burst_seq_addr.sv
module burst_seq_addr #(
  parameter int AW = 16,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          order_ilv,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr_q
);
  localparam int UW = AW - LW;

  logic [LW-1:0] base_lo;
  logic [LW-1:0] beat_q;
  logic [LW-1:0] beat_nx;
  logic [LW-1:0] lo_ilv;
  logic [LW-1:0] lo_lin;
  logic [LW-1:0] lo_nx;

  assign beat_nx = beat_q + 1'b1;

  // interleaved order: each low bit flips by the matching beat bit
  for (genvar b = 0; b < LW; b++) begin : g_ilv
    assign lo_ilv[b] = base_lo[b] ^ beat_nx[b];
  end

  // linear order wraps naturally at the width of the low field
  assign lo_lin = base_lo + beat_nx;
  assign lo_nx  = order_ilv ? lo_ilv : lo_lin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      base_lo <= '0;
      beat_q  <= '0;
    end else if (load) begin
      addr_q  <= ext_addr;
      base_lo <= ext_addr[LW-1:0];
      beat_q  <= '0;
    end else if (step) begin
      addr_q[LW-1:0] <= lo_nx;
      beat_q         <= beat_nx;
    end
  end

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_q == $past(ext_addr)); // R5

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> addr_q[AW-1:LW] == $past(addr_q[AW-1:LW])); // R8

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr_q)); // R9 R10

  initial begin
    AST_WIDTHS: assert (UW > 0 && LW > 0); // R8
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          stb_gated_n,
  input  logic          stb_free_n,
  input  logic          adv_n,
  input  logic          order_ilv,
  input  logic          ce_main_n,
  input  logic          ce_hi_a,
  input  logic          ce_hi_b,
  input  logic          ce_lo_a_n,
  input  logic          ce_lo_b_n,
  output logic [AW-1:0] mem_addr,
  output logic          sel_q,
  output logic [1:0]    cyc_type
);
  logic strobe_edge;
  logic enables_ok;
  logic load;
  logic step;
  cyc_e cyc_q;

  burst_seq_sel u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb_gated_n (stb_gated_n),
    .stb_free_n  (stb_free_n),
    .ce_main_n   (ce_main_n),
    .ce_hi_a     (ce_hi_a),
    .ce_hi_b     (ce_hi_b),
    .ce_lo_a_n   (ce_lo_a_n),
    .ce_lo_b_n   (ce_lo_b_n),
    .strobe_edge (strobe_edge),
    .enables_ok  (enables_ok),
    .sel_q       (sel_q)
  );

  burst_seq_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_edge (strobe_edge),
    .enables_ok  (enables_ok),
    .sel_q       (sel_q),
    .adv_n       (adv_n),
    .load        (load),
    .step        (step),
    .cyc_q       (cyc_q)
  );

  burst_seq_addr #(.AW(AW), .LW(LW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .order_ilv (order_ilv),
    .ext_addr  (ext_addr),
    .addr_q    (mem_addr)
  );

  assign cyc_type = cyc_q;

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CYC_WAIT) |-> mem_addr == $past(mem_addr)); // R9
endmodule

// File: tb/burst_seq_tb_top.sv
`timescale 1ns/1ps
module burst_seq_tb_top;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ea = '0;
  logic sg = 1'b1, sf = 1'b1, adv = 1'b1, mode = 1'b1;
  logic cm = 1'b0, ha = 1'b1, hb = 1'b1, la = 1'b0, lb = 1'b0;
  logic [AW-1:0] mem_addr;
  logic sel_q;
  logic [1:0] cyc_type;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic          m_sel = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [1:0]    m_base = '0;
  logic [1:0]    m_beat = '0;
  logic [1:0]    m_type = 2'b00;

  always #2.5 clk = ~clk;

  burst_seq #(.AW(AW), .LW(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_addr(ea),
    .stb_gated_n(sg), .stb_free_n(sf), .adv_n(adv), .order_ilv(mode),
    .ce_main_n(cm), .ce_hi_a(ha), .ce_hi_b(hb), .ce_lo_a_n(la), .ce_lo_b_n(lb),
    .mem_addr(mem_addr), .sel_q(sel_q), .cyc_type(cyc_type)
  );

  function automatic logic [1:0] beat_lo(logic [1:0] base, logic [1:0] n, logic ilv);
    return ilv ? (base ^ n) : (base + n);
  endfunction

  task automatic check(string tag);
    logic [AW+2:0] act, exp;
    act = {sel_q, cyc_type, mem_addr};
    exp = {m_sel, m_type, m_addr};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act sel=%0b cyc=%0d addr=%h exp sel=%0b cyc=%0d addr=%h",
               tag, sel_q, cyc_type, mem_addr, m_sel, m_type, m_addr);
    end
  endtask

  // advance the model one edge using the current inputs
  task automatic model_edge();
    logic se, ok;
    se = (!sg && !cm) || !sf;
    ok = !cm && ha && hb && !la && !lb;
    if (se) begin
      m_sel = ok;
      if (ok) begin
        m_addr = ea; m_base = ea[1:0]; m_beat = 2'd0; m_type = 2'b01;
      end else m_type = 2'b00;
    end else if (m_sel) begin
      if (!adv) begin
        m_beat = m_beat + 2'd1;
        m_addr[1:0] = beat_lo(m_base, m_beat, mode);
        m_type = 2'b10;
      end else m_type = 2'b11;
    end else m_type = 2'b00;
  endtask

  task automatic tick(string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle_in();
    sg = 1'b1; sf = 1'b1; adv = 1'b1;
    cm = 1'b0; ha = 1'b1; hb = 1'b1; la = 1'b0; lb = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle_in();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    check("R1");

    // every offset, both orders, full wrap
    for (int md = 0; md < 2; md++) begin
      for (int off = 0; off < 4; off++) begin
        mode = md[0];
        idle_in(); sf = 1'b0; adv = 1'b0; ea = {14'h2A5C + 14'(off), off[1:0]};
        tick("R5");
        idle_in(); adv = 1'b0;
        for (int k = 0; k < 4; k++) tick(md == 1 ? "R6" : "R7");
        tick("R8");
      end
    end

    // suspension mid burst
    mode = 1'b0;
    idle_in(); sg = 1'b0; ea = 16'h7FFF;
    tick("R5");
    idle_in(); adv = 1'b0; tick("R7");
    adv = 1'b1; tick("R9"); tick("R9");
    adv = 1'b0; tick("R9");
    // enables change without strobe: selection kept
    ha = 1'b0; cm = 1'b1; adv = 1'b1; tick("R3");

    // each bad enable on a strobe edge
    for (int e = 0; e < 5; e++) begin
      idle_in(); sf = 1'b0; ea = 16'h1234;
      case (e)
        0: cm = 1'b1;
        1: ha = 1'b0;
        2: hb = 1'b0;
        3: la = 1'b1;
        default: lb = 1'b1;
      endcase
      tick("R2");
      idle_in(); sf = 1'b0; ea = 16'h4321; tick("R2");
    end

    // deselected, no strobe
    idle_in(); sf = 1'b0; hb = 1'b0; tick("R2");
    idle_in(); adv = 1'b0; tick("R10"); tick("R10");
    // gated strobe masked while deselected
    cm = 1'b1; sg = 1'b0; ea = 16'hBEEF; tick("R4");
    // gated strobe accepted
    idle_in(); sg = 1'b0; ea = 16'hC0DE; mode = 1'b1; tick("R4");
    // masked gated strobe while selected acts as no strobe
    idle_in(); cm = 1'b1; sg = 1'b0; adv = 1'b0; ea = 16'h0001; tick("R4");
    // free strobe with primary high deselects
    idle_in(); cm = 1'b1; sf = 1'b0; tick("R4");
    // both strobes low, adv ignored
    idle_in(); sg = 1'b0; sf = 1'b0; adv = 1'b0; ea = 16'h5A5A; tick("R5");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      sg = ($urandom % 4) != 0;
      sf = ($urandom % 4) != 0;
      adv = $urandom % 2;
      mode = ($urandom % 8) != 0 ? mode : ~mode;
      cm = ($urandom % 8) == 0;
      ha = ($urandom % 10) != 0;
      hb = ($urandom % 10) != 0;
      la = ($urandom % 10) == 0;
      lb = ($urandom % 10) == 0;
      ea = AW'($urandom);
      tick("R11");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule